// File: doc/BRIEF.md
# Gen2 Link-Stall Recovery Monitor

This block looks at a PCIe link each time a check is requested. Its aim is to catch a link whose move to Gen2 speed has stalled in the receiver-lock state of recovery. It takes two 32-bit link debug words. From these it uses one link indication bit and the 6-bit LTSSM state code. It also reads a receive-status register in the PHY through a simple request/done register access port. A separate access engine serves that port and is not part of this block.

When the block finds the stall, it raises a stall pulse and reads the PHY receiver override register. It sets the receiver data-enable and PLL-enable override bits in that value and writes it back. It then waits for a programmable number of clock cycles, chosen well below the LTSSM timeout. Last, it reads the override register again and clears the same two bits. Any other bits the PHY changed in the meantime are kept.

A completed check ends with a one-cycle done pulse. An error flag and the link-up result are valid with that pulse.

Top module: `lsr_monitor`

## Requirements
- R1: When a check starts and debug bit 36 is set (bit 4 of `dbg_hi_i`), the check completes with `link_up_o`=1, `err_o`=0, no PHY access and no stall pulse.
- R2: Otherwise the first PHY access is a read of register 0x100D.
- R3: If bit 0 (rx_valid) of the value read from 0x100D is 1, the check completes after that single access with `link_up_o`=0 and no stall pulse.
- R4: If the LTSSM state (bits 5:0 of `dbg_lo_i`) is not 0x0D, the check completes after the single read with no stall pulse, whatever the upper bits of `dbg_lo_i` hold.
- R5: With rx_valid 0 and state 0x0D, `stall_o` pulses exactly once. The block then reads 0x1005 and writes back the read value OR 0x0028 (bit 5 and bit 3 set).
- R6: After the set write completes, no request is issued for `HOLD_CYC` cycles. The next access, a read of 0x1005, begins `HOLD_CYC`+1 cycles after the set write's done.
- R7: The final access writes the value just re-read from 0x1005 AND NOT 0x0028, so every other bit the PHY holds at that time is kept.
- R8: An access that returns `acc_err_i` with its done ends the check at once with `err_o`=1. No further access follows, and override bits already written stay as they are.
- R9: A `chk_req_i` pulse that arrives while `busy_o` is high is ignored and starts no second check.
- R10: Once `acc_req_o` is raised, it stays high with stable address, direction and write data until `acc_done_i`.
- R11: After reset the block is idle: `busy_o`, `acc_req_o`, `done_o`, `stall_o`, `err_o` and `link_up_o` are all 0.
- R12: `done_o` is a one-cycle pulse, and `busy_o` is low in the cycle after it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| chk_req_i | input | 1 | Start a check (ignored while busy) |
| dbg_lo_i | input | 32 | Lower link debug word; bits 5:0 are the LTSSM state |
| dbg_hi_i | input | 32 | Upper link debug word; bit 4 is the link indication |
| acc_req_o | output | 1 | PHY register access request |
| acc_wr_o | output | 1 | 1 for write, 0 for read |
| acc_addr_o | output | 16 | PHY register address |
| acc_wdata_o | output | 16 | Write data |
| acc_done_i | input | 1 | Access complete (one cycle) |
| acc_err_i | input | 1 | Access failed, valid with done |
| acc_rdata_i | input | 16 | Read data, valid with done |
| link_up_o | output | 1 | Result of the most recent check |
| stall_o | output | 1 | One-cycle pulse when a stall is found |
| busy_o | output | 1 | A check is in progress |
| done_o | output | 1 | One-cycle pulse at the end of a check |
| err_o | output | 1 | Last check aborted on an access error |

## Verification
Two events can fall in the same cycle.

The first pair is an access-error response and the completion of the override set write. The bench fails the set write itself. It then judges that the done pulse carries the error, that no hold or clear access follows, and that the override register still holds its earlier value.

The second pair is a new check request and an ongoing recovery. The bench pulses `chk_req_i` during the read phase and again during the hold. It judges through the scoreboard's access queue that exactly one sequence ran and that `busy_o` falls after the single done pulse.

// File: rtl/lsr_pkg.sv
package lsr_pkg;
   typedef enum logic [2:0] {
      ST_IDLE,
      ST_RD_RXV,
      ST_RD_SET,
      ST_WR_SET,
      ST_HOLD,
      ST_RD_CLR,
      ST_WR_CLR,
      ST_FIN
   } lsr_state_t;

   function automatic logic [15:0] lsr_apply(input logic [15:0] val,
                                             input logic [15:0] mask,
                                             input logic        set);
      return set ? (val | mask) : (val & ~mask);
   endfunction
endpackage

// File: rtl/lsr_sync_stages.sv
module lsr_sync_stages #(
   parameter int WIDTH  = 7,
   parameter int STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d_i,
   output logic [WIDTH-1:0] q_o
);
   if (STAGES < 0 || STAGES > 4) begin : g_bad_stages
      $error("lsr_sync_stages: STAGES must be 0..4");
   end

   if (STAGES == 0) begin : g_pass
      assign q_o = d_i;
   end else begin : g_flops
      logic [WIDTH-1:0] pipe [STAGES];
      for (genvar s = 0; s < STAGES; s++) begin : g_st
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) pipe[s] <= '0;
            else if (s == 0) pipe[s] <= d_i;
            else pipe[s] <= pipe[(s == 0) ? 0 : s-1];
         end
      end
      assign q_o = pipe[STAGES-1];
   end
endmodule

// File: rtl/lsr_stall_detect.sv
module lsr_stall_detect #(
   parameter int          DBG_W       = 32,
   parameter int          DATA_W      = 16,
   parameter int          LTSSM_W     = 6,
   parameter logic [5:0]  STALL_CODE  = 6'h0D,
   parameter int          LINK_BIT    = 36,
   parameter int          RXV_BIT     = 0,
   parameter int          SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [DBG_W-1:0]  dbg_lo_i,
   input  logic [DBG_W-1:0]  dbg_hi_i,
   input  logic [DATA_W-1:0] rxv_rdata_i,
   output logic              link_o,
   output logic              stall_o
);
   localparam int HI_IDX = LINK_BIT - DBG_W;
   localparam int SW     = LTSSM_W + 1;

   if (LINK_BIT < DBG_W || LINK_BIT >= 2*DBG_W) begin : g_bad_link
      $error("lsr_stall_detect: LINK_BIT must lie in the upper debug word");
   end
   if (LTSSM_W > 6 || LTSSM_W > DBG_W) begin : g_bad_ltssm
      $error("lsr_stall_detect: LTSSM_W out of range");
   end
   if (RXV_BIT >= DATA_W) begin : g_bad_rxv
      $error("lsr_stall_detect: RXV_BIT out of range");
   end

   logic [SW-1:0] raw, synced;
   assign raw = {dbg_hi_i[HI_IDX], dbg_lo_i[LTSSM_W-1:0]};

   lsr_sync_stages #(.WIDTH(SW), .STAGES(SYNC_STAGES)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d_i   (raw),
      .q_o   (synced)
   );

   assign link_o  = synced[SW-1];
   assign stall_o = !rxv_rdata_i[RXV_BIT] &&
                    (synced[LTSSM_W-1:0] == STALL_CODE[LTSSM_W-1:0]);

   logic unused_dbg;
   assign unused_dbg = ^{dbg_lo_i, dbg_hi_i};
endmodule

// File: rtl/lsr_hold_timer.sv
module lsr_hold_timer #(
   parameter int HOLD_CYC = 500000
) (
   input  logic clk,
   input  logic rst_n,
   input  logic load_i,
   output logic expired_o
);
   localparam int CW = $clog2(HOLD_CYC + 1);
   localparam logic [CW-1:0] LOAD_VAL = CW'(HOLD_CYC - 1);

   if (HOLD_CYC < 1) begin : g_bad_hold
      $error("lsr_hold_timer: HOLD_CYC must be at least 1");
   end

   logic [CW-1:0] cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)           cnt <= '0;
      else if (load_i)      cnt <= LOAD_VAL;
      else if (cnt != '0)   cnt <= cnt - 1'b1;
   end

   assign expired_o = (cnt == '0);

   AST_TMR_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
      cnt <= LOAD_VAL);  // R6
   AST_TMR_COUNTS: assert property (@(posedge clk) disable iff (!rst_n)
      (!load_i && cnt != '0) |=> (cnt == $past(cnt) - 1'b1));  // R6
endmodule

// File: rtl/lsr_monitor.sv
module lsr_monitor
   import lsr_pkg::*;
#(
   parameter int          DBG_W       = 32,
   parameter int          ADDR_W      = 16,
   parameter int          DATA_W      = 16,
   parameter int          LTSSM_W     = 6,
   parameter logic [5:0]  STALL_CODE  = 6'h0D,
   parameter int          LINK_BIT    = 36,
   parameter int          RXV_BIT     = 0,
   parameter logic [15:0] RXV_REG     = 16'h100D,
   parameter logic [15:0] OVR_REG     = 16'h1005,
   parameter int          DEN_BIT     = 5,
   parameter int          PLL_BIT     = 3,
   parameter int          HOLD_CYC    = 500000,
   parameter int          SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              chk_req_i,
   input  logic [DBG_W-1:0]  dbg_lo_i,
   input  logic [DBG_W-1:0]  dbg_hi_i,
   output logic              acc_req_o,
   output logic              acc_wr_o,
   output logic [ADDR_W-1:0] acc_addr_o,
   output logic [DATA_W-1:0] acc_wdata_o,
   input  logic              acc_done_i,
   input  logic              acc_err_i,
   input  logic [DATA_W-1:0] acc_rdata_i,
   output logic              link_up_o,
   output logic              stall_o,
   output logic              busy_o,
   output logic              done_o,
   output logic              err_o
);
   localparam logic [DATA_W-1:0] OVR_MASK =
      (DATA_W'(1) << DEN_BIT) | (DATA_W'(1) << PLL_BIT);

   if (DATA_W != 16 || ADDR_W < 16) begin : g_bad_width
      $error("lsr_monitor: DATA_W must be 16 and ADDR_W at least 16");
   end
   if (DEN_BIT >= DATA_W || PLL_BIT >= DATA_W || DEN_BIT == PLL_BIT) begin : g_bad_bits
      $error("lsr_monitor: override bit positions invalid");
   end

   lsr_state_t        state, state_nx;
   logic [DATA_W-1:0] ovr_q, ovr_nx;
   logic              link_q, link_nx, err_q, err_nx, stall_q, stall_nx;
   logic              link_bit, stall_hit, hold_load, hold_done;
   logic              acc_ok;

   lsr_stall_detect #(
      .DBG_W(DBG_W), .DATA_W(DATA_W), .LTSSM_W(LTSSM_W),
      .STALL_CODE(STALL_CODE), .LINK_BIT(LINK_BIT), .RXV_BIT(RXV_BIT),
      .SYNC_STAGES(SYNC_STAGES)
   ) u_detect (
      .clk         (clk),
      .rst_n       (rst_n),
      .dbg_lo_i    (dbg_lo_i),
      .dbg_hi_i    (dbg_hi_i),
      .rxv_rdata_i (acc_rdata_i),
      .link_o      (link_bit),
      .stall_o     (stall_hit)
   );

   lsr_hold_timer #(.HOLD_CYC(HOLD_CYC)) u_hold (
      .clk       (clk),
      .rst_n     (rst_n),
      .load_i    (hold_load),
      .expired_o (hold_done)
   );

   assign acc_ok    = acc_done_i && !acc_err_i;
   assign hold_load = (state == ST_WR_SET) && acc_ok;

   always_comb begin
      state_nx = state;
      ovr_nx   = ovr_q;
      link_nx  = link_q;
      err_nx   = err_q;
      stall_nx = 1'b0;
      unique case (state)
         ST_IDLE: if (chk_req_i) begin
            err_nx = 1'b0;
            if (link_bit) begin
               link_nx  = 1'b1;
               state_nx = ST_FIN;
            end else begin
               link_nx  = 1'b0;
               state_nx = ST_RD_RXV;
            end
         end
         ST_HOLD: if (hold_done) state_nx = ST_RD_CLR;
         ST_FIN:  state_nx = ST_IDLE;
         default: if (acc_done_i) begin
            if (acc_err_i) begin
               err_nx   = 1'b1;
               state_nx = ST_FIN;
            end else begin
               unique case (state)
                  ST_RD_RXV: if (stall_hit) begin
                     stall_nx = 1'b1;
                     state_nx = ST_RD_SET;
                  end else begin
                     state_nx = ST_FIN;
                  end
                  ST_RD_SET: begin
                     ovr_nx   = lsr_apply(acc_rdata_i, OVR_MASK, 1'b1);
                     state_nx = ST_WR_SET;
                  end
                  ST_WR_SET: state_nx = ST_HOLD;
                  ST_RD_CLR: begin
                     ovr_nx   = lsr_apply(acc_rdata_i, OVR_MASK, 1'b0);
                     state_nx = ST_WR_CLR;
                  end
                  default:   state_nx = ST_FIN;
               endcase
            end
         end
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state   <= ST_IDLE;
         ovr_q   <= '0;
         link_q  <= 1'b0;
         err_q   <= 1'b0;
         stall_q <= 1'b0;
      end else begin
         state   <= state_nx;
         ovr_q   <= ovr_nx;
         link_q  <= link_nx;
         err_q   <= err_nx;
         stall_q <= stall_nx;
      end
   end

   always_comb begin
      acc_req_o = 1'b0;
      acc_wr_o  = 1'b0;
      unique case (state)
         ST_RD_RXV, ST_RD_SET, ST_RD_CLR: acc_req_o = 1'b1;
         ST_WR_SET, ST_WR_CLR: begin
            acc_req_o = 1'b1;
            acc_wr_o  = 1'b1;
         end
         default: ;
      endcase
   end

   assign acc_addr_o  = (state == ST_RD_RXV) ? ADDR_W'(RXV_REG) : ADDR_W'(OVR_REG);
   assign acc_wdata_o = acc_wr_o ? ovr_q : '0;
   assign link_up_o   = link_q;
   assign err_o       = err_q;
   assign stall_o     = stall_q;
   assign busy_o      = (state != ST_IDLE);
   assign done_o      = (state == ST_FIN);

   AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (acc_req_o && !acc_done_i) |=> (acc_req_o && $stable(acc_addr_o) &&
         $stable(acc_wr_o) && $stable(acc_wdata_o)));  // R10
   AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |=> (!done_o && !busy_o));  // R12
   AST_LINK_SHORTCUT: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy_o && chk_req_i && link_bit) |=> (done_o && link_up_o && !acc_req_o));  // R1
   AST_HOLD_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_HOLD) |-> !acc_req_o);  // R6
   AST_STALL_START: assert property (@(posedge clk) disable iff (!rst_n)
      stall_o |-> (acc_req_o && !acc_wr_o && state == ST_RD_SET));  // R5
   AST_ERR_ABORT: assert property (@(posedge clk) disable iff (!rst_n)
      (acc_req_o && acc_done_i && acc_err_i) |=> (done_o && err_o && !acc_req_o));  // R8
   AST_FIRST_READ: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy_o && chk_req_i && !link_bit) |=>
         (acc_req_o && !acc_wr_o && acc_addr_o == ADDR_W'(RXV_REG)));  // R2
   AST_BUSY_IGNORE: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_o && !done_o) |=> busy_o);  // R9
endmodule

// File: tb/tb_lsr_monitor.sv
`timescale 1ns/1ps
module tb_lsr_monitor;
   localparam int H   = 40;
   localparam int LAT = 2;

   typedef struct packed {
      logic        wr;
      logic [15:0] addr;
      logic [15:0] data;
   } acc_t;

   logic clk = 1'b0, rst_n = 1'b0, chk_req_i = 1'b0;
   logic [31:0] dbg_lo_i = '0, dbg_hi_i = '0;
   logic acc_req_o, acc_wr_o, acc_done_i = 1'b0, acc_err_i = 1'b0;
   logic [15:0] acc_addr_o, acc_wdata_o, acc_rdata_i = '0;
   logic link_up_o, stall_o, busy_o, done_o, err_o;

   int checks = 0, fails = 0, cyc = 0, stall_cnt = 0;
   int acc_idx = 0, fail_idx = -1, last_done = 0;
   bit gap_pending = 0, tweak = 0, finished = 0;
   logic [15:0] reg_rx = '0, reg_ovr = '0;
   acc_t exp_q[$];

   always #2.5 clk = ~clk;

   lsr_monitor #(.HOLD_CYC(H)) dut (.*);

   task automatic chk(input bit ok, input string req, input string what,
                      input int act, input int expv);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, expv);
      end
   endtask

   task automatic push(input logic wr, input logic [15:0] a, input logic [15:0] d);
      acc_t e;
      e.wr = wr; e.addr = a; e.data = d;
      exp_q.push_back(e);
   endtask

   always @(posedge clk) cyc <= cyc + 1;
   always @(negedge clk) if (rst_n && stall_o) stall_cnt++;

   // access engine model with scoreboard monitor
   initial begin
      int cnt = 0;
      forever begin
         @(posedge clk);
         #1;
         acc_done_i = 1'b0;
         acc_err_i  = 1'b0;
         if (acc_req_o) begin
            if (cnt == 0 && gap_pending && !acc_wr_o && acc_addr_o == 16'h1005) begin
               chk(cyc - last_done == H + 1, "R6", "hold gap", cyc - last_done, H + 1);
               gap_pending = 0;
            end
            if (cnt == LAT) begin
               acc_t e;
               if (exp_q.size() == 0) begin
                  chk(0, "R8", "unexpected access", int'(acc_addr_o), 0);
               end else begin
                  e = exp_q.pop_front();
                  chk(acc_wr_o == e.wr && acc_addr_o == e.addr, "R2", "access kind/addr",
                      int'({acc_wr_o, acc_addr_o}), int'({e.wr, e.addr}));
                  if (e.wr)
                     chk(acc_wdata_o == e.data, (e.data & 16'h0028) != 0 ? "R5" : "R7",
                         "write data", int'(acc_wdata_o), int'(e.data));
               end
               if (acc_idx == fail_idx) begin
                  acc_err_i = 1'b1;
               end else if (acc_wr_o) begin
                  if (acc_addr_o == 16'h1005) reg_ovr = acc_wdata_o;
                  if (acc_wdata_o[5]) begin
                     gap_pending = 1;
                     if (tweak) reg_ovr = reg_ovr ^ 16'h0100;
                  end
               end else begin
                  acc_rdata_i = (acc_addr_o == 16'h100D) ? reg_rx : reg_ovr;
               end
               acc_done_i = 1'b1;
               last_done  = cyc;
               acc_idx++;
               cnt = 0;
            end else begin
               cnt++;
            end
         end
      end
   end

   task automatic run(input string req, input logic [31:0] lo, input logic [31:0] hi,
                      input bit exp_link, input bit exp_err, input int exp_stall,
                      input bit poke);
      @(negedge clk);
      dbg_lo_i = lo; dbg_hi_i = hi;
      acc_idx = 0; stall_cnt = 0; gap_pending = 0;
      repeat (4) @(negedge clk);
      chk_req_i = 1'b1;
      @(negedge clk);
      chk_req_i = 1'b0;
      if (poke) begin
         repeat (2) @(negedge clk);
         chk_req_i = 1'b1;               // R9: request during the read phase
         @(negedge clk);
         chk_req_i = 1'b0;
         repeat (12) @(negedge clk);
         chk_req_i = 1'b1;               // R9: request during the hold
         @(negedge clk);
         chk_req_i = 1'b0;
      end
      while (!done_o) @(negedge clk);
      chk(link_up_o == exp_link, req, "link_up", link_up_o, exp_link);
      chk(err_o == exp_err, req, "err", err_o, exp_err);
      chk(stall_cnt == exp_stall, req, "stall pulses", stall_cnt, exp_stall);
      @(negedge clk);
      chk(!busy_o && !done_o, "R12", "busy/done after done", {busy_o, done_o}, 0);
      repeat (LAT + 4) @(negedge clk);
      chk(exp_q.size() == 0 && !busy_o, req, "pending accesses", exp_q.size(), 0);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      chk({busy_o, acc_req_o, done_o, stall_o, err_o, link_up_o} == 6'b0, "R11",
          "reset outputs", {busy_o, acc_req_o, done_o, stall_o, err_o, link_up_o}, 0);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);

      // R1: link bit set, no PHY access
      run("R1", 32'h0000_000D, 32'h0000_0010, 1'b1, 1'b0, 0, 0);

      // R3: rx_valid set, stall state present
      reg_rx = 16'h0001;
      push(0, 16'h100D, 0);
      run("R3", 32'h0000_000D, 32'hFFFF_FFEF, 1'b0, 1'b0, 0, 0);

      // R4: other LTSSM state, high bits full of ones
      reg_rx = 16'hFFFE;
      push(0, 16'h100D, 0);
      run("R4", 32'hFFFF_FFCC, 32'h0, 1'b0, 1'b0, 0, 0);

      // R5 R6 R7: stall recovery, PHY flips bit 8 during the hold
      reg_ovr = 16'h1234; tweak = 1;
      push(0, 16'h100D, 0);
      push(0, 16'h1005, 0);
      push(1, 16'h1005, 16'h123C);
      push(0, 16'h1005, 0);
      push(1, 16'h1005, 16'h1314);
      run("R5", 32'hABCD_E04D, 32'h0, 1'b0, 1'b0, 1, 0);
      chk(reg_ovr == 16'h1314, "R7", "override reg final", reg_ovr, 16'h1314);
      tweak = 0;

      // R9: repeated requests while busy
      reg_ovr = 16'h0000;
      push(0, 16'h100D, 0);
      push(0, 16'h1005, 0);
      push(1, 16'h1005, 16'h0028);
      push(0, 16'h1005, 0);
      push(1, 16'h1005, 16'h0000);
      run("R9", 32'h0000_000D, 32'h0, 1'b0, 1'b0, 1, 1);

      // R8: set write fails, override untouched
      reg_ovr = 16'h00F0; fail_idx = 2;
      push(0, 16'h100D, 0);
      push(0, 16'h1005, 0);
      push(1, 16'h1005, 16'h00F8);
      run("R8", 32'h0000_000D, 32'h0, 1'b0, 1'b1, 1, 0);
      chk(reg_ovr == 16'h00F0, "R8", "override reg after abort", reg_ovr, 16'h00F0);

      // R8: first read fails
      fail_idx = 0;
      push(0, 16'h100D, 0);
      run("R8", 32'h0000_000D, 32'h0, 1'b0, 1'b1, 0, 0);
      fail_idx = -1;

      // R1 again after an error: err clears
      run("R1", 32'h0, 32'h0000_0010, 1'b1, 1'b0, 0, 0);

      finished = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!finished) begin
         checks++;
         fails++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   end
endmodule